// File: doc/BRIEF.md
# Repeated-Addition Sequential Multiplier

This block multiplies two unsigned operands without a hardware multiplier. A small controller steers a datapath of three registers. One register holds the latched multiplicand. One counts the additions still to be done. One accumulates the product. Each busy clock cycle adds the multiplicand to the accumulator once, and the number of additions equals the multiplier operand.

A requester waits for `ready_o` to be high and then pulses `start_i` with both operands valid. The block latches the operands on that edge and drops `ready_o`. It raises `ready_o` again when `prod_o` holds the full product, and `prod_o` keeps that value until the next accepted start.

If either operand is zero, the addition loop is skipped and the product is cleared directly. A zero multiplicand therefore costs no cycles beyond one. There is no software-visible state and only one request can be in flight.

Top module: `rep_add_mul`

## Requirements
- R1: While `rst_ni` is low and after it is released, `ready_o` reads 1 and `prod_o` reads 0 until the first accepted start.
- R2: A start sampled high while `ready_o` is 1, with both operands nonzero, makes `ready_o` read 0 for exactly b+1 consecutive cycles, where b is the latched multiplier value.
- R3: When `ready_o` returns to 1, `prod_o` equals the unsigned product of the two operands latched at the accepted start.
- R4: A start accepted with `a_i` equal to 0 or `b_i` equal to 0 makes `ready_o` read 0 for exactly one cycle, and `prod_o` reads 0 during that cycle and afterwards.
- R5: While `ready_o` is 1 and `start_i` is 0, `prod_o` holds its value whatever `a_i` and `b_i` do.
- R6: While `ready_o` is 0, `start_i`, `a_i` and `b_i` are ignored: the busy length and the final product depend only on the operands latched at acceptance.
- R7: During a busy period, `prod_o` never decreases. After k addition cycles it equals k times the latched multiplicand.
- R8: In the first busy cycle after a nonzero start, `prod_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiplication; taken only while ready_o is 1 |
| a_i | input | OP_W (8) | Unsigned multiplicand |
| b_i | input | OP_W (8) | Unsigned multiplier, which is also the addition count |
| ready_o | output | 1 | High when idle and able to take a request |
| prod_o | output | 2*OP_W (16) | Unsigned product and accumulator value |

## Verification
The hardest case to reach is the end of the longest loop, 255 × 255. There the counter has to run down through every value while the accumulator reaches its largest possible value without wrapping. The bench requests that product directly. During the run it keeps `start_i` high and changes both operands on every cycle, so any leak of the inputs into a busy run shows up as a wrong length or a wrong product.

Two other cases are driven explicitly. One is a start on the very first cycle that `ready_o` comes back high. The other is the one-addition case, b = 1, where the loop exits on its first decrement.

// File: rtl/rep_add_mul_pkg.sv
package rep_add_mul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ZERO  = 2'd1,
    ST_SETUP = 2'd2,
    ST_ADD   = 2'd3
  } ctl_state_e;

  typedef enum logic [1:0] {
    RSEL_HOLD = 2'd0,
    RSEL_CLR  = 2'd1,
    RSEL_ADD  = 2'd2
  } r_sel_e;

  typedef enum logic [1:0] {
    NSEL_HOLD = 2'd0,
    NSEL_LOAD = 2'd1,
    NSEL_DEC  = 2'd2
  } n_sel_e;

endpackage

// File: rtl/rep_add_mul_ctrl.sv
module rep_add_mul_ctrl
  import rep_add_mul_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   opnd_zero_i,
  input  logic   cnt_last_i,
  output logic   ready_o,
  output logic   a_ld_o,
  output r_sel_e r_sel_o,
  output n_sel_e n_sel_o
);

  ctl_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    a_ld_o  = 1'b0;
    r_sel_o = RSEL_HOLD;
    n_sel_o = NSEL_HOLD;
    ready_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        ready_o = 1'b1;
        if (start_i) begin
          a_ld_o  = 1'b1;
          r_sel_o = RSEL_CLR;
          n_sel_o = NSEL_LOAD;
          state_d = opnd_zero_i ? ST_ZERO : ST_SETUP;
        end
      end
      // zero operand: product already cleared, one cycle back to idle
      ST_ZERO:  state_d = ST_IDLE;
      ST_SETUP: state_d = ST_ADD;
      ST_ADD: begin
        r_sel_o = RSEL_ADD;
        n_sel_o = NSEL_DEC;
        if (cnt_last_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/rep_add_mul_dpath.sv
module rep_add_mul_dpath
  import rep_add_mul_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int PROD_W = 2 * OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  input  logic              a_ld_i,
  input  r_sel_e            r_sel_i,
  input  n_sel_e            n_sel_i,
  output logic              opnd_zero_o,
  output logic              cnt_last_o,
  output logic [PROD_W-1:0] prod_o
);

  logic [OP_W-1:0]   a_q;
  logic [OP_W-1:0]   n_q, n_d, n_dec;
  logic [PROD_W-1:0] r_q, r_d, r_sum;

  assign n_dec = n_q - OP_W'(1);
  assign r_sum = r_q + PROD_W'(a_q);

  // status to controller
  assign opnd_zero_o = (a_i == '0) || (b_i == '0);
  assign cnt_last_o  = (n_dec == '0);

  always_comb begin
    unique case (n_sel_i)
      NSEL_LOAD: n_d = b_i;
      NSEL_DEC:  n_d = n_dec;
      default:   n_d = n_q;
    endcase
  end

  always_comb begin
    unique case (r_sel_i)
      RSEL_CLR: r_d = '0;
      RSEL_ADD: r_d = r_sum;
      default:  r_d = r_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      n_q <= '0;
      r_q <= '0;
    end else begin
      if (a_ld_i) a_q <= a_i;
      n_q <= n_d;
      r_q <= r_d;
    end
  end

  assign prod_o = r_q;

endmodule

// File: rtl/rep_add_mul.sv
module rep_add_mul
  import rep_add_mul_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int PROD_W = 2 * OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic              ready_o,
  output logic [PROD_W-1:0] prod_o
);

  logic   a_ld, opnd_zero, cnt_last;
  r_sel_e r_sel;
  n_sel_e n_sel;

  rep_add_mul_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .opnd_zero_i (opnd_zero),
    .cnt_last_i  (cnt_last),
    .ready_o     (ready_o),
    .a_ld_o      (a_ld),
    .r_sel_o     (r_sel),
    .n_sel_o     (n_sel)
  );

  rep_add_mul_dpath #(
    .OP_W   (OP_W),
    .PROD_W (PROD_W)
  ) u_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .a_i         (a_i),
    .b_i         (b_i),
    .a_ld_i      (a_ld),
    .r_sel_i     (r_sel),
    .n_sel_i     (n_sel),
    .opnd_zero_o (opnd_zero),
    .cnt_last_o  (cnt_last),
    .prod_o      (prod_o)
  );

endmodule

// File: rtl/rep_add_mul_chk.sv
module rep_add_mul_chk #(
  parameter int OP_W   = 8,
  parameter int PROD_W = 2 * OP_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [OP_W-1:0]   a_i,
  input logic [OP_W-1:0]   b_i,
  input logic              ready_o,
  input logic [PROD_W-1:0] prod_o
);

  logic [OP_W-1:0] op_a_q, op_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_a_q <= '0;
      op_b_q <= '0;
    end else if (ready_o && start_i) begin
      op_a_q <= a_i;
      op_b_q <= b_i;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> ready_o);

  assert_setup_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i && a_i != '0 && b_i != '0) |=> (!ready_o && prod_o == '0));

  assert_final_prod_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (prod_o == PROD_W'(op_a_q) * PROD_W'(op_b_q)));

  assert_zero_skip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i && (a_i == '0 || b_i == '0)) |=> (!ready_o && prod_o == '0) ##1 ready_o);

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> (ready_o && $stable(prod_o)));

  assert_monotonic_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> (prod_o >= $past(prod_o)));

endmodule

bind rep_add_mul rep_add_mul_chk #(
  .OP_W   (OP_W),
  .PROD_W (PROD_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .ready_o (ready_o),
  .prod_o  (prod_o)
);

// File: tb/tb_rep_add_mul.sv
`timescale 1ns/1ps
module tb_rep_add_mul;
  localparam int OP_W   = 8;
  localparam int PROD_W = 16;

  logic              clk_i   = 1'b0;
  logic              rst_ni  = 1'b0;
  logic              start_i = 1'b0;
  logic [OP_W-1:0]   a_i     = '0;
  logic [OP_W-1:0]   b_i     = '0;
  logic              ready_o;
  logic [PROD_W-1:0] prod_o;

  rep_add_mul #(.OP_W(OP_W), .PROD_W(PROD_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .a_i(a_i), .b_i(b_i), .ready_o(ready_o), .prod_o(prod_o)
  );

  always #2.5 clk_i = ~clk_i;

  int    n_chk = 0;
  int    n_fail = 0;
  int    m_left = 0;
  int    m_r = 0;
  int    m_a = 0;
  bit    m_setup = 0;
  string tag_rdy = "R1";
  string tag_r   = "R1";

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // one clock: drive, advance the model at the edge, compare after it
  task automatic cyc(bit st, int a, int b);
    start_i = st;
    a_i = OP_W'(a);
    b_i = OP_W'(b);
    @(posedge clk_i);
    if (m_left == 0) begin
      if (st) begin
        m_r = 0;
        if (a % 256 == 0 || b % 256 == 0) begin
          m_a = 0; m_left = 1; m_setup = 0;
        end else begin
          m_a = a % 256; m_left = (b % 256) + 1; m_setup = 1;
        end
      end
    end else begin
      if (m_setup) m_setup = 0;
      else         m_r = m_r + m_a;
      m_left--;
    end
    #1;
    check(tag_rdy, "ready_o", longint'(ready_o), longint'(m_left == 0));
    check(tag_r, "prod_o", longint'(prod_o), longint'(m_r));
  endtask

  // accepted request, then busy with start held and operands churning (R6)
  task automatic run_op(int a, int b, bit churn);
    cyc(1, a, b);
    while (m_left > 0) cyc(churn, (a + 37 * m_left) % 256, (b + 11 * m_left) % 256);
    check("R3", "final product", longint'(prod_o), longint'(a * b));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R2 watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", "ready_o in reset", longint'(ready_o), 1);
    check("R1", "prod_o in reset", longint'(prod_o), 0);
    rst_ni = 1'b1;
    #1;
    tag_rdy = "R1"; tag_r = "R1";
    cyc(0, 12, 34);
    cyc(0, 0, 0);

    tag_rdy = "R2"; tag_r = "R7";
    run_op(7, 5, 0);
    tag_r = "R5";
    for (int i = 0; i < 4; i++) cyc(0, i * 50, 255 - i);

    tag_rdy = "R2"; tag_r = "R8";
    run_op(1, 1, 0);
    run_op(3, 1, 1);
    run_op(1, 200, 0);

    tag_rdy = "R6"; tag_r = "R6";
    run_op(255, 255, 1);
    run_op(13, 9, 1);

    tag_rdy = "R4"; tag_r = "R4";
    run_op(0, 9, 0);
    run_op(9, 0, 1);
    run_op(0, 0, 0);
    tag_r = "R5";
    cyc(0, 77, 88);

    // back-to-back: restart on the first ready cycle
    tag_rdy = "R2"; tag_r = "R3";
    run_op(100, 4, 0);
    run_op(6, 250, 0);
    run_op(0, 3, 0);
    run_op(17, 2, 1);
    tag_r = "R5";
    for (int i = 0; i < 3; i++) cyc(0, 255, 255);

    summary();
    $finish;
  end

endmodule